// File: doc/BRIEF.md
# Serial CORDIC Numerically Controlled Oscillator

This block is a phase-accumulating oscillator that turns a 32-bit tuning word into signed sine and cosine samples. A single CORDIC rotation engine is reused over successive clocks. It performs one micro-rotation per clock, so with a precision of `PREC` bits the block delivers one sine/cosine pair every `PREC` clock cycles. The output frequency is `phase_inc * f_sample / 2^32`, where `f_sample` is the sample rate (one sample every `PREC` clocks). For example, `phase_inc = 42949673` produces a tone at one hundredth of the sample rate.

The tuning word and the two modulation words are taken together on a single clock edge in each sample period. This is the "load" edge, the enabled edge that starts a new rotation. Their values on every other edge are ignored. The frequency modulation word is added to the increment before accumulation. The phase modulation word offsets only the phase handed to the rotation engine and never reaches the accumulator.

The rotation engine folds the phase into the first quadrant using its top two bits. It rotates a gain-compensated start vector `PREC` times, using a constant arctangent table, and then restores the signs and the sine/cosine swap for the quadrant. The clock enable stalls the whole block without losing any state. `PREC` may range from 8 to 30.

Top module: `nco_serial_cordic`

## Requirements
- R1: While `rst_n` is low, `sin_out`, `cos_out` and `out_valid` are all zero. After release, `out_valid` stays low until a sample has been completed under `clken`.
- R2: `out_valid` is high after exactly one enabled edge in every `PREC` enabled edges. Consecutive new samples are exactly `PREC` enabled edges apart.
- R3: The first pair after reset is presented after the (`PREC`+1)th enabled edge following reset release. This is a latency of `PREC` enabled edges from the edge that sampled its inputs.
- R4: Each pair is within 4 LSB of round(32767·sin θ) and round(32767·cos θ), with 16-bit precision. Here θ = 2π·φ/2^32 and φ is the sample phase. This holds in all four quadrants.
- R5: At phase zero, the cosine lies in 32764..32767 (never above 32767) and the sine lies within ±4 of zero.
- R6: Without modulation, sample k has phase k·`phase_inc` mod 2^32. With increment 42949673, sample 25 has sine ≥ 32763.
- R7: `phase_inc`, `phase_mod` and `freq_mod` are used only on the load edge. Their values on all other edges have no effect on any later sample.
- R8: `freq_mod` is added to `phase_inc` on each load edge, and the sum is accumulated. Its effect on phase therefore persists in later samples.
- R9: The sample phase is the accumulator value plus `phase_mod`. `phase_mod` is never accumulated.
- R10: While `clken` is low, the outputs, `out_valid`, the accumulator and the iteration position hold their values. Once `clken` returns, the sequence continues as if the stalled cycles had not occurred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clken | input | 1 | Clock enable; low stalls the block |
| phase_inc | input | 32 | Unsigned phase increment per sample |
| phase_mod | input | 32 | Phase offset added to the sample phase |
| freq_mod | input | 32 | Offset added to the increment before accumulation |
| sin_out | output | PREC | Signed sine sample |
| cos_out | output | PREC | Signed cosine sample |
| out_valid | output | 1 | A new sample pair is presented |

## Verification
The only time base that matters is enabled edges. A load edge samples the inputs, and the pair built from that phase is registered on the next load edge, `PREC` enabled edges later. `out_valid` is registered on that same edge.

The bench advances its own model on every enabled edge and samples all outputs 2 ns after each rising edge. The expected value for that edge is therefore already settled. After a stalled edge, the bench instead expects all outputs to be unchanged.

Inputs change on falling edges, and junk values are driven only on edges that the model knows are not load edges.

// File: rtl/nco_pkg.sv
package nco_pkg;
  localparam int ACC_W = 32;
  typedef logic [ACC_W-1:0] phase_t;

  // 1/1.6467602581 in Q30
  localparam longint GAIN_Q30 = 64'd652032874;

  // arctan(2^-i) as a fraction of a full turn, scaled to 2^32
  function automatic phase_t atan_step(input int unsigned i);
    case (i)
      0:  atan_step = 32'd536870912;
      1:  atan_step = 32'd316933406;
      2:  atan_step = 32'd167458907;
      3:  atan_step = 32'd85004756;
      4:  atan_step = 32'd42667331;
      5:  atan_step = 32'd21354465;
      6:  atan_step = 32'd10679838;
      7:  atan_step = 32'd5340245;
      8:  atan_step = 32'd2670163;
      9:  atan_step = 32'd1335087;
      10: atan_step = 32'd667544;
      11: atan_step = 32'd333772;
      12: atan_step = 32'd166886;
      13: atan_step = 32'd83443;
      14: atan_step = 32'd41722;
      15: atan_step = 32'd20861;
      default: atan_step = 32'((64'd683565276 + (64'd1 << (i - 1))) >> i);
    endcase
  endfunction

  // gain-compensated start magnitude with GUARD extra fraction bits
  function automatic longint start_mag(input int prec, input int guard);
    return (GAIN_Q30 << (prec - 1 + guard)) >> 30;
  endfunction
endpackage

// File: rtl/nco_phase_acc.sv
module nco_phase_acc
  import nco_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   load,
  input  phase_t inc,
  input  phase_t fmod,
  input  phase_t pmod,
  output phase_t sample_phase
);
  phase_t acc_q;

  assign sample_phase = acc_q + pmod;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    acc_q <= '0;
    else if (load) acc_q <= acc_q + inc + fmod;
  end

  // R10 R7
  acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(acc_q));
endmodule

// File: rtl/nco_cordic_iter.sv
module nco_cordic_iter
  import nco_pkg::*;
#(
  parameter int PREC  = 16,
  parameter int GUARD = 4,
  parameter int CW    = $clog2(PREC),
  localparam int DW   = PREC + GUARD + 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic                 step,
  input  logic [CW-1:0]        idx,
  input  phase_t               phase_in,
  output logic signed [DW-1:0] x_o,
  output logic signed [DW-1:0] y_o,
  output logic [1:0]           quad_o
);
  localparam logic signed [DW-1:0] X0 = DW'(start_mag(PREC, GUARD));

  logic signed [DW-1:0]    x_q, y_q;
  logic signed [ACC_W-1:0] z_q;
  logic [1:0]              quad_q;
  logic signed [DW-1:0]    x_sh, y_sh;
  logic signed [ACC_W-1:0] ang;

  assign x_sh = x_q >>> idx;
  assign y_sh = y_q >>> idx;
  assign ang  = $signed(atan_step(32'(idx)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q <= '0; y_q <= '0; z_q <= '0; quad_q <= '0;
    end else if (load) begin
      // the first micro-rotation always turns positive from a zero y
      x_q    <= X0;
      y_q    <= X0;
      z_q    <= $signed({2'b00, phase_in[ACC_W-3:0]}) - $signed(atan_step(0));
      quad_q <= phase_in[ACC_W-1:ACC_W-2];
    end else if (step) begin
      if (z_q >= 0) begin
        x_q <= x_q - y_sh; y_q <= y_q + x_sh; z_q <= z_q - ang;
      end else begin
        x_q <= x_q + y_sh; y_q <= y_q - x_sh; z_q <= z_q + ang;
      end
    end
  end

  assign x_o    = x_q;
  assign y_o    = y_q;
  assign quad_o = quad_q;

  // R2
  step_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (idx != '0));
  // R10
  iter_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step) |=> ($stable(x_q) && $stable(z_q) && $stable(quad_q)));
endmodule

// File: rtl/nco_out_stage.sv
module nco_out_stage #(
  parameter int PREC  = 16,
  parameter int GUARD = 4,
  localparam int DW   = PREC + GUARD + 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   en,
  input  logic                   take,
  input  logic signed [DW-1:0]   x_i,
  input  logic signed [DW-1:0]   y_i,
  input  logic [1:0]             quad_i,
  output logic signed [PREC-1:0] sin_o,
  output logic signed [PREC-1:0] cos_o,
  output logic                   valid_o
);
  localparam logic signed [DW-1:0] HALF = DW'(2 ** (GUARD - 1));
  localparam logic signed [DW-1:0] MAXV = DW'(2 ** (PREC - 1) - 1);
  localparam logic signed [DW-1:0] MINV = -MAXV - DW'(1);

  function automatic logic signed [PREC-1:0] round_sat(input logic signed [DW-1:0] v);
    logic signed [DW-1:0] r;
    r = (v + HALF) >>> GUARD;
    if (r > MAXV)      r = MAXV;
    else if (r < MINV) r = MINV;
    return r[PREC-1:0];
  endfunction

  logic signed [DW-1:0] c_full, s_full;

  always_comb begin
    unique case (quad_i)
      2'd0: begin c_full = x_i;  s_full = y_i;  end
      2'd1: begin c_full = -y_i; s_full = x_i;  end
      2'd2: begin c_full = -x_i; s_full = -y_i; end
      default: begin c_full = y_i; s_full = -x_i; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sin_o <= '0; cos_o <= '0; valid_o <= 1'b0;
    end else if (en) begin
      valid_o <= take;
      if (take) begin
        sin_o <= round_sat(s_full);
        cos_o <= round_sat(c_full);
      end
    end
  end

  // R10
  out_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(valid_o) && $stable(sin_o) && $stable(cos_o)));
  // R2
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> ($stable(sin_o) && $stable(cos_o)));
endmodule

// File: rtl/nco_serial_cordic.sv
module nco_serial_cordic
  import nco_pkg::*;
#(
  parameter int PREC  = 16,
  parameter int GUARD = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clken,
  input  logic [31:0]            phase_inc,
  input  logic [31:0]            phase_mod,
  input  logic [31:0]            freq_mod,
  output logic signed [PREC-1:0] sin_out,
  output logic signed [PREC-1:0] cos_out,
  output logic                   out_valid
);
  localparam int CW = $clog2(PREC);
  localparam int DW = PREC + GUARD + 2;
  localparam logic [CW-1:0] LAST = CW'(PREC - 1);

  logic [CW-1:0]        iter_cnt;
  logic                 primed;
  logic                 load_evt, step_evt, take_evt;
  phase_t               sample_phase;
  logic signed [DW-1:0] x_w, y_w;
  logic [1:0]           quad_w;

  assign load_evt = clken && (iter_cnt == '0);
  assign step_evt = clken && (iter_cnt != '0);
  assign take_evt = load_evt && primed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iter_cnt <= '0;
      primed   <= 1'b0;
    end else if (clken) begin
      iter_cnt <= (iter_cnt == LAST) ? '0 : iter_cnt + CW'(1);
      if (load_evt) primed <= 1'b1;
    end
  end

  nco_phase_acc u_acc (
    .clk(clk), .rst_n(rst_n), .load(load_evt),
    .inc(phase_inc), .fmod(freq_mod), .pmod(phase_mod),
    .sample_phase(sample_phase)
  );

  nco_cordic_iter #(.PREC(PREC), .GUARD(GUARD), .CW(CW)) u_iter (
    .clk(clk), .rst_n(rst_n), .load(load_evt), .step(step_evt),
    .idx(iter_cnt), .phase_in(sample_phase),
    .x_o(x_w), .y_o(y_w), .quad_o(quad_w)
  );

  nco_out_stage #(.PREC(PREC), .GUARD(GUARD)) u_out (
    .clk(clk), .rst_n(rst_n), .en(clken), .take(take_evt),
    .x_i(x_w), .y_i(y_w), .quad_i(quad_w),
    .sin_o(sin_out), .cos_o(cos_out), .valid_o(out_valid)
  );

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iter_cnt <= LAST);
  // R2 R3
  valid_on_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_evt |=> out_valid);
  // R2
  valid_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clken && !load_evt) |=> !out_valid);
  // R10
  seq_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clken |=> ($stable(iter_cnt) && $stable(primed)));
  // R1
  no_early_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !primed |-> !out_valid);
endmodule

// File: tb/tb_nco_serial_cordic.sv
module tb_nco_serial_cordic;
  localparam int N   = 16;
  localparam int AMP = 2 ** (N - 1) - 1;
  localparam int TOL = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clken = 1'b0;
  logic [31:0] phase_inc = '0, phase_mod = '0, freq_mod = '0;
  logic signed [N-1:0] sin_out, cos_out;
  logic out_valid;

  nco_serial_cordic #(.PREC(N)) dut (
    .clk(clk), .rst_n(rst_n), .clken(clken),
    .phase_inc(phase_inc), .phase_mod(phase_mod), .freq_mod(freq_mod),
    .sin_out(sin_out), .cos_out(cos_out), .out_valid(out_valid)
  );

  always #5 clk = ~clk;

  int total = 0, bad = 0, cycles = 0;
  string tag = "R4";
  // bench model
  int unsigned m_cnt = 0, en_edges = 0, gap = 0;
  bit m_primed = 0, exp_due = 0, seen_first = 0, en_edge = 0;
  bit r5_done = 0, r6_done = 0;
  logic [31:0] m_acc = '0, m_prev = '0, exp_phase = '0;
  logic [31:0] t_inc = '0, t_pm = '0, t_fm = '0;
  logic signed [N-1:0] p_sin = '0, p_cos = '0;
  bit p_valid = 0;

  function automatic int ref_amp(input logic [31:0] ph, input bit want_sin);
    real a, v;
    a = 6.283185307179586 * real'(ph) / 4294967296.0;
    v = (want_sin ? $sin(a) : $cos(a)) * real'(AMP);
    return $rtoi(v + ((v >= 0.0) ? 0.5 : -0.5));
  endfunction

  function automatic int absd(input int a, input int b);
    return (a > b) ? a - b : b - a;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d (t=%0t)", req, what, act, expv, $time);
    end
  endtask

  task automatic report();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    en_edge = rst_n && clken;
    if (!rst_n) begin
      m_cnt = 0; m_acc = '0; m_primed = 0; exp_due = 0; en_edges = 0; gap = 0;
    end else if (clken) begin
      en_edges++; gap++;
      if (m_cnt == 0) begin
        exp_due = m_primed; exp_phase = m_prev;
        m_prev = m_acc + phase_mod;
        m_acc  = m_acc + phase_inc + freq_mod;
        m_primed = 1;
      end else exp_due = 0;
      m_cnt = (m_cnt == N - 1) ? 0 : m_cnt + 1;
    end
    #2;
    if (!rst_n) begin
      // R1
      check(sin_out == 0 && cos_out == 0 && out_valid == 0, "R1", "reset outputs",
            int'(sin_out) + int'(cos_out) + int'(out_valid), 0);
    end else if (!en_edge) begin
      // R10 stalled edge: everything holds
      check(out_valid == p_valid && sin_out == p_sin && cos_out == p_cos, "R10",
            "stall hold", int'(sin_out), int'(p_sin));
    end else begin
      // R2 R1 strobe agrees with the sample schedule
      check(out_valid == exp_due, "R2", "valid strobe", int'(out_valid), int'(exp_due));
      if (out_valid) begin
        if (seen_first) check(gap == N, "R2", "valid spacing", int'(gap), N);
        else            check(en_edges == N + 1, "R3", "first latency", int'(en_edges), N + 1);
        seen_first = 1; gap = 0;
        check(absd(int'(sin_out), ref_amp(exp_phase, 1)) <= TOL, tag, "sine",
              int'(sin_out), ref_amp(exp_phase, 1));
        check(absd(int'(cos_out), ref_amp(exp_phase, 0)) <= TOL, tag, "cosine",
              int'(cos_out), ref_amp(exp_phase, 0));
        if (exp_phase == 32'd0 && !r5_done) begin
          r5_done = 1;
          // R5
          check(int'(cos_out) >= AMP - 3 && int'(cos_out) <= AMP, "R5", "cos at zero",
                int'(cos_out), AMP);
          check(absd(int'(sin_out), 0) <= TOL, "R5", "sin at zero", int'(sin_out), 0);
        end
        if (exp_phase == 32'd1073741825 && !r6_done) begin
          r6_done = 1;
          // R6
          check(int'(sin_out) >= AMP - 4, "R6", "sample 25 peak", int'(sin_out), AMP);
        end
      end
    end
    p_sin = sin_out; p_cos = cos_out; p_valid = out_valid;
  end

  // en: clock enable; junk: scramble inputs on non-load edges; fresh: new random words per load
  task automatic drive(input bit en, input bit junk, input bit fresh);
    @(negedge clk);
    clken = en;
    if (en && m_cnt == 0) begin
      if (fresh) begin t_inc = $urandom; t_pm = $urandom; t_fm = $urandom % 32'h0100_0000; end
      phase_inc = t_inc; phase_mod = t_pm; freq_mod = t_fm;
    end else if (junk) begin
      phase_inc = $urandom; phase_mod = $urandom; freq_mod = $urandom;
    end else begin
      phase_inc = t_inc; phase_mod = t_pm; freq_mod = t_fm;
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    // R1: released but not enabled
    repeat (3) drive(1'b0, 1'b0, 1'b0);
    // R3 R5 R6: plain tone at 1/100 of the sample rate
    tag = "R4"; t_inc = 32'd42949673; t_pm = '0; t_fm = '0;
    repeat (30 * N) drive(1'b1, 1'b0, 1'b0);
    // R7 R8: frequency offset with junk between loads
    tag = "R8"; t_fm = 32'd7777777;
    repeat (20 * N) drive(1'b1, 1'b1, 1'b0);
    // R9: quarter-turn phase offset
    tag = "R9"; t_fm = '0; t_pm = 32'h4000_0000;
    repeat (10 * N) drive(1'b1, 1'b1, 1'b0);
    // R7 R4 R10: random words, random stalls
    tag = "R7";
    for (int i = 0; i < 300 * N; i++) drive(($urandom % 4) != 0, 1'b1, 1'b1);
    // R10: long stall mid-rotation, then resume
    tag = "R10";
    repeat (5) drive(1'b1, 1'b1, 1'b0);
    repeat (40) drive(1'b0, 1'b1, 1'b0);
    repeat (6 * N) drive(1'b1, 1'b1, 1'b0);
    @(negedge clk);
    check(r5_done && r6_done, "R5", "directed samples seen", int'(r5_done) + int'(r6_done), 2);
    report();
  end

  initial begin
    wait (cycles >= 100000);
    bad++; total++;
    $display("FAIL R2 watchdog: actual=%0d expected=<100000", cycles);
    report();
  end
endmodule